// File: doc/BRIEF.md
# Character Row Pattern Fetch with Cursor Overlay

This block produces the five dots of one pixel row of one character cell on a dot-matrix display. The display scanner presents an 8-bit character code and a 3-bit row index. The block then decides where the glyph comes from. Codes whose high nibble is zero read a small writable store of user glyphs (16 characters of 8 rows by 5 dots). All other codes are passed to an external read-only glyph port, and its 5-bit answer is used. The row is registered and appears one clock after the request.

The scanner also gives the display-memory address of the cell it is fetching. When that address matches the current address counter, the cell is the cursor cell. The cursor is then drawn on top of the glyph. An underline lights all dots of the last row (row index 7), ORed with any stored data there. A blinking block lights every dot of every row while the blink phase is on. The blink phase flips after each 32 frame pulses. The cursor is hidden while the address counter points into user-glyph memory.

A host port writes the user-glyph store with a 7-bit address, and a separate read returns data one clock after the address is presented.

Top module: `glyph_row_fetch`

## Requirements
- R1: A code with bits 7..4 all zero takes its row from the user-glyph store; any other code takes `rom_dots`. A code of 0x10 already counts as a read-only-port code.
- R2: The user-glyph address is {code[3:0], row[2:0]}. Stored bits 4..0 are the five dots, and a 1 lights the dot.
- R3: `dots` is registered and shows the fetch presented on the previous clock edge. `rom_code` and `rom_row` mirror `char_code` and `row_idx` in the same cycle.
- R4: At the cursor cell, with `ul_en` high and row index 7, `dots` is 5'b11111. With `ul_en` low, row 7 shows its stored data, and rows 0..6 are never changed by the underline.
- R5: At the cursor cell, with `blink_en` high and `blink_phase` high, every row reads 5'b11111. With `blink_phase` low, the blink adds nothing.
- R6: No cursor overlay appears when `cell_addr` differs from `ac_addr`, or when `ac_in_upat` is high.
- R7: `blink_phase` starts at 0 and inverts on the 32nd `frame_tick` pulse after reset, and on every 32nd pulse after that.
- R8: A host write with `h_wr` stores `h_wdata` at `h_addr` in one clock. `h_rdata` shows the word at the `h_addr` presented on the previous edge.
- R9: During reset, `dots`, `h_rdata` and `blink_phase` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_code | input | 8 | Character code of the cell being fetched |
| row_idx | input | 3 | Pixel row within the cell, 7 is the cursor row |
| cell_addr | input | 7 | Display-memory address of the cell |
| ac_addr | input | 7 | Current address counter value |
| ac_in_upat | input | 1 | Address counter points into user-glyph memory |
| ul_en | input | 1 | Underline cursor enable |
| blink_en | input | 1 | Blinking block cursor enable |
| frame_tick | input | 1 | One-cycle pulse per display frame |
| rom_code | output | 8 | Code forwarded to the external glyph port |
| rom_row | output | 3 | Row forwarded to the external glyph port |
| rom_dots | input | 5 | Row answer from the external glyph port, same cycle |
| h_wr | input | 1 | Host write strobe for the user-glyph store |
| h_addr | input | 7 | Host address {char[3:0], row[2:0]} |
| h_wdata | input | 5 | Host write data |
| h_rdata | output | 5 | Host read data, one cycle after address |
| dots | output | 5 | Registered pixel row, bit 4 leftmost |
| blink_phase | output | 1 | Current blink phase |

## Verification
The assertions take for granted that `rom_dots` is a combinational answer that is stable in the cycle its code is presented. They also take for granted that `frame_tick` is a pulse of one cycle, and that the host never writes and reads-for-check the same word in one cycle. The stimulus changes every input only on the falling clock edge, holds `rom_dots` at all ones or all zeros for the whole request, and pulses `frame_tick` for single cycles with gaps. It also fills every user-glyph word before any display read, so no read sees unwritten storage.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int CODE_W   = 8;
  localparam int ROW_W    = 3;
  localparam int DOT_W    = 5;
  localparam int UCHARS   = 16;
  localparam int UC_W     = $clog2(UCHARS);
  localparam int UPAT_AW  = UC_W + ROW_W;
  localparam int DD_AW    = 7;
  localparam int BLINK_FR = 32;

  typedef enum logic {SRC_UPAT = 1'b0, SRC_ROM = 1'b1} glyph_src_e;
endpackage

// File: rtl/upat_store.sv
module upat_store #(
  parameter int AW = 7,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_rd_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] host_q,
  input  logic [AW-1:0] disp_addr,
  output logic [DW-1:0] disp_dots
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] host_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_rd_addr] <= wr_data;
  end

  always_comb host_d = mem[wr_rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_q <= '0;
    else        host_q <= host_d;
  end

  always_comb disp_dots = mem[disp_addr];

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_rd_addr)] == $past(wr_data));
endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int FRAMES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic phase
);
  localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase;
    if (frame_tick) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        phase_d = ~phase;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      phase <= phase_d;
    end
  end

  p_phase_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && cnt_q == LAST) |=> phase != $past(phase));
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_tick && cnt_q == LAST) |=> phase == $past(phase));
endmodule

// File: rtl/cursor_merge.sv
module cursor_merge #(
  parameter int DW = 5,
  parameter int RW = 3
) (
  input  logic [DW-1:0] base,
  input  logic [RW-1:0] row,
  input  logic          at_cursor,
  input  logic          ul_en,
  input  logic          blink_en,
  input  logic          phase,
  output logic [DW-1:0] merged
);
  localparam logic [RW-1:0] CUR_ROW = '1;

  logic ul_on, blk_on;

  always_comb begin
    ul_on  = at_cursor && ul_en && (row == CUR_ROW);
    blk_on = at_cursor && blink_en && phase;
    merged = base | {DW{ul_on | blk_on}};
  end
endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import glyph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] char_code,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [DD_AW-1:0]  cell_addr,
  input  logic [DD_AW-1:0]  ac_addr,
  input  logic              ac_in_upat,
  input  logic              ul_en,
  input  logic              blink_en,
  input  logic              frame_tick,
  output logic [CODE_W-1:0] rom_code,
  output logic [ROW_W-1:0]  rom_row,
  input  logic [DOT_W-1:0]  rom_dots,
  input  logic              h_wr,
  input  logic [UPAT_AW-1:0] h_addr,
  input  logic [DOT_W-1:0]  h_wdata,
  output logic [DOT_W-1:0]  h_rdata,
  output logic [DOT_W-1:0]  dots,
  output logic              blink_phase
);
  glyph_src_e       src;
  logic [UPAT_AW-1:0] disp_addr;
  logic [DOT_W-1:0] upat_dots, base, merged, dots_d;
  logic             at_cursor;

  always_comb begin
    rom_code  = char_code;
    rom_row   = row_idx;
    src       = (char_code[CODE_W-1:UC_W] == '0) ? SRC_UPAT : SRC_ROM;
    disp_addr = {char_code[UC_W-1:0], row_idx};
    at_cursor = (cell_addr == ac_addr) && !ac_in_upat;
  end

  upat_store #(.AW(UPAT_AW), .DW(DOT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (h_wr),
    .wr_rd_addr (h_addr),
    .wr_data    (h_wdata),
    .host_q     (h_rdata),
    .disp_addr  (disp_addr),
    .disp_dots  (upat_dots)
  );

  blink_gen #(.FRAMES(BLINK_FR)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .phase      (blink_phase)
  );

  always_comb base = (src == SRC_UPAT) ? upat_dots : rom_dots;

  cursor_merge #(.DW(DOT_W), .RW(ROW_W)) u_cursor (
    .base      (base),
    .row       (row_idx),
    .at_cursor (at_cursor),
    .ul_en     (ul_en),
    .blink_en  (blink_en),
    .phase     (blink_phase),
    .merged    (merged)
  );

  always_comb dots_d = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dots <= '0;
    else        dots <= dots_d;
  end

  p_rom_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (char_code[CODE_W-1:UC_W] != '0 && cell_addr != ac_addr) |=> dots == $past(rom_dots));
  p_upat_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (char_code[CODE_W-1:UC_W] == '0 && cell_addr != ac_addr) |=> dots == $past(upat_dots));
  p_underline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_addr == ac_addr && !ac_in_upat && ul_en && row_idx == '1) |=> dots == '1);
  p_blink_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_addr == ac_addr && !ac_in_upat && blink_en && blink_phase) |=> dots == '1);
  p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ac_in_upat |=> dots == $past(base));
endmodule

// File: tb/tb_glyph_row_fetch.sv
module tb_glyph_row_fetch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] char_code;
  logic [2:0] row_idx;
  logic [6:0] cell_addr, ac_addr;
  logic       ac_in_upat, ul_en, blink_en, frame_tick;
  logic [7:0] rom_code;
  logic [2:0] rom_row;
  logic [4:0] rom_dots;
  logic       h_wr;
  logic [6:0] h_addr;
  logic [4:0] h_wdata, h_rdata, dots;
  logic       blink_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  glyph_row_fetch dut (
    .clk(clk), .rst_n(rst_n), .char_code(char_code), .row_idx(row_idx),
    .cell_addr(cell_addr), .ac_addr(ac_addr), .ac_in_upat(ac_in_upat),
    .ul_en(ul_en), .blink_en(blink_en), .frame_tick(frame_tick),
    .rom_code(rom_code), .rom_row(rom_row), .rom_dots(rom_dots),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .dots(dots), .blink_phase(blink_phase)
  );

  // fill pattern: word(a) = (a*7+3) mod 32
  function automatic logic [4:0] pat(input int a);
    return 5'((a * 7 + 3) % 32);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {code[20:13], row[12:10], rom1[9], ul[8], blk[7], hit[6], inh[5], exp[4:0]}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h03}, // R1 R2 word 0
    {8'h05, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h10}, // R2 word 43, rom ignored
    {8'h0F, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h1C}, // R2 word 127, no hit
    {8'h41, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h1F}, // R1 rom ones
    {8'h41, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h00}, // R1 rom zeros
    {8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h00}, // R1 boundary 0x10
    {8'h02, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h1F}, // R4 underline
    {8'h02, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'h04}, // R4 off: stored row 7
    {8'h02, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h1D}, // R4 row 6 untouched
    {8'h80, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'h00}, // R6 inhibit
    {8'h80, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h00}, // R6 not cursor cell
    {8'h80, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h1F}, // R4 on rom code
    {8'h90, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00}  // R5 phase 0
  };

  task automatic fetch(input logic [7:0] c, input logic [2:0] r, input logic rom1,
                       input logic ul, input logic blk, input logic hit, input logic inh);
    @(negedge clk);
    char_code  = c;
    row_idx    = r;
    rom_dots   = rom1 ? 5'h1F : 5'h00;
    ul_en      = ul;
    blink_en   = blk;
    cell_addr  = hit ? 7'd5 : 7'd9;
    ac_in_upat = inh;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; char_code = '0; row_idx = '0; cell_addr = 7'd9; ac_addr = 7'd5;
    ac_in_upat = 1'b0; ul_en = 1'b0; blink_en = 1'b0; frame_tick = 1'b0;
    rom_dots = '0; h_wr = 1'b0; h_addr = '0; h_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 dots", 8'(dots), 8'h00);
    chk("R9 h_rdata", 8'(h_rdata), 8'h00);
    chk("R9 blink_phase", 8'(blink_phase), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 128; a++) begin
      h_wr = 1'b1; h_addr = 7'(a); h_wdata = pat(a);
      @(negedge clk);
    end
    h_wr = 1'b0;
    for (int v = 0; v < NV; v++) begin
      fetch(VEC[v][20:13], VEC[v][12:10], VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5]);
      chk($sformatf("R1/R2/R4/R5/R6 vector %0d", v), 8'(dots), 8'(VEC[v][4:0]));
    end
    // R3 pass-through and one-cycle latency
    @(negedge clk);
    char_code = 8'h03; row_idx = 3'd5; cell_addr = 7'd9; ul_en = 1'b0; blink_en = 1'b0;
    #1;
    chk("R3 rom_code", rom_code, 8'h03);
    chk("R3 rom_row", 8'(rom_row), 8'h05);
    chk("R3 dots not yet updated", 8'(dots), 8'h00);
    @(negedge clk);
    chk("R3 dots after one edge", 8'(dots), 8'(pat(8'h1D)));
    // R8 host read latency and overwrite
    h_addr = 7'd23; @(negedge clk);
    chk("R8 host read", 8'(h_rdata), 8'(pat(23)));
    h_wr = 1'b1; h_addr = 7'd23; h_wdata = 5'h15; @(negedge clk);
    h_wr = 1'b0; @(negedge clk);
    chk("R8 host read after write", 8'(h_rdata), 8'h15);
    fetch(8'h02, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 display sees new word", 8'(dots), 8'h15);
    // R7 blink phase
    ticks(31);
    chk("R7 phase after 31 ticks", 8'(blink_phase), 8'h00);
    ticks(1);
    chk("R7 phase after 32 ticks", 8'(blink_phase), 8'h01);
    fetch(8'h90, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 blink block on", 8'(dots), 8'h1F);
    fetch(8'h01, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 blink block on upat code", 8'(dots), 8'h1F);
    fetch(8'h90, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 blink inhibited", 8'(dots), 8'h00);
    fetch(8'h90, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 blink other cell", 8'(dots), 8'h00);
    ticks(32);
    chk("R7 phase back to 0", 8'(blink_phase), 8'h00);
    fetch(8'h90, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 blink phase 0 dark", 8'(dots), 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule